// File: doc/BRIEF.md
# Command Address Chain Detector

This block watches completed accesses on a host memory bus and looks for a fixed chain of six reads. The first five reads must hit five set addresses in a set order. The sixth read picks the command: one address asks for a store, another asks for a recall. When the whole chain matches, the block raises a one-cycle request toward the controller that carries out the transfer. The block never looks at data and does not move anything itself.

Each access is counted once, when the completed-access strobe rises. The access must also be qualified by chip enable or by output enable, or it must carry the write flag. A read that breaks the chain throws away all progress. A write anywhere inside the chain does the same. The one exception is a breaking read of the chain's first address, which is taken as a new first step.

While the controller reports busy (a transfer is running, or accesses are inhibited), the detector keeps its progress cleared and ignores the bus. As a result, no access can be matched from the moment a command fires until the controller lets go.

Top module: `nvseq_cmd_detect`

## Requirements
- R1: After reset, store_req and recall_req are both low and no chain progress is kept.
- R2: Reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0, with we_on low, raise store_req for exactly one cycle. The pulse comes in the clock cycle after the edge at which the sixth rise of acc_done is sampled.
- R3: The same five-read prefix followed by a read of 0x4C63 raises recall_req for exactly one cycle, with the same timing as R2.
- R4: A read of any address other than the next expected one aborts the chain. Later reads of the remaining addresses then produce no request.
- R5: An access with we_on high inside the chain aborts it, even when its address equals the expected one.
- R6: A step counts whether the read is qualified by ce_rd, by oe_rd, or by both. A single chain may mix the two.
- R7: A breaking read of 0x4E38 restarts the chain at step two. The four following prefix reads and a command read then complete it.
- R8: Each rise of acc_done counts as one access, however long acc_done stays high. A request is never high in two cycles in a row.
- R9: While busy is high, accesses are ignored and progress is cleared. A chain interrupted by busy, or completed while busy is high, produces no request.
- R10: store_req and recall_req are never high in the same cycle.
- R11: After a command fires, progress starts from empty. A lone command-address read then produces nothing, and a prefix followed by any other sixth address produces nothing.
- R12: A rise of acc_done with ce_rd, oe_rd and we_on all low is not an access and leaves chain progress unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Controller busy or inhibit; clears and freezes the detector |
| acc_done | input | 1 | Completed-access strobe; counted on its rising edge |
| ce_rd | input | 1 | Access qualified by chip enable |
| oe_rd | input | 1 | Access qualified by output enable |
| we_on | input | 1 | Write flag of the access |
| addr | input | 16 | Access address |
| store_req | output | 1 | One-cycle store command request |
| recall_req | output | 1 | One-cycle recall command request |

## Verification
Chain progress is internal, so a wrong step value shows at the ports only when a chain ends. It appears as a missing request, a request of the wrong kind, or a request after an aborted chain, one cycle after the final access. The scenarios therefore end every abort, restart, busy and no-strobe case with a full or partial chain. The final access of each chain decides whether a pulse is due. Every cycle with no pulse due is also checked for silence, so stray or stretched pulses are caught in the cycle they occur.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int ADDR_W   = 16;
  localparam int NUM_KEYS = 5;
  localparam int STEP_W   = $clog2(NUM_KEYS + 1);

  localparam logic [ADDR_W-1:0] STORE_CODE  = 16'h8FC0;
  localparam logic [ADDR_W-1:0] RECALL_CODE = 16'h4C63;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_STORE  = 2'b01,
    CMD_RECALL = 2'b10
  } cmd_e;

  function automatic logic [ADDR_W-1:0] key_at(input int idx);
    case (idx)
      0:       key_at = 16'h4E38;
      1:       key_at = 16'hB1C7;
      2:       key_at = 16'h83E0;
      3:       key_at = 16'h7C1F;
      default: key_at = 16'h703F;
    endcase
  endfunction
endpackage

// File: rtl/nvseq_rst_sync.sv
module nvseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/nvseq_access_edge.sv
module nvseq_access_edge (
  input  logic clk,
  input  logic rst_ns,
  input  logic acc_done,
  input  logic ce_rd,
  input  logic oe_rd,
  input  logic we_on,
  output logic rd_evt,
  output logic wr_evt
);
  logic done_q;
  logic done_d;
  logic rise;

  always_comb begin
    done_d = acc_done;
    rise   = acc_done & ~done_q;
    wr_evt = rise & we_on;
    rd_evt = rise & ~we_on & (ce_rd | oe_rd);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) done_q <= 1'b0;
    else         done_q <= done_d;
  end
endmodule

// File: rtl/nvseq_key_match.sv
module nvseq_key_match
  import nvseq_pkg::*;
#(
  parameter int N = NUM_KEYS,
  parameter int W = ADDR_W
) (
  input  logic [W-1:0] addr,
  output logic [N-1:0] key_hit,
  output logic         store_hit,
  output logic         recall_hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    localparam logic [W-1:0] KEY = W'(key_at(g));
    assign key_hit[g] = (addr == KEY);
  end

  assign store_hit  = (addr == W'(STORE_CODE));
  assign recall_hit = (addr == W'(RECALL_CODE));
endmodule

// File: rtl/nvseq_chain_fsm.sv
module nvseq_chain_fsm
  import nvseq_pkg::*;
#(
  parameter int N  = NUM_KEYS,
  parameter int SW = STEP_W
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic         busy,
  input  logic         rd_evt,
  input  logic         wr_evt,
  input  logic [N-1:0] key_hit,
  input  logic         store_hit,
  input  logic         recall_hit,
  output cmd_e         cmd_q
);
  localparam logic [SW-1:0] LAST = SW'(N);

  logic [SW-1:0] step_q, step_d;
  logic          step_en;
  cmd_e          cmd_d;
  logic          cur_hit;
  logic [SW-1:0] restart;

  always_comb begin
    cur_hit = 1'b0;
    for (int i = 0; i < N; i++)
      if (step_q == SW'(i)) cur_hit = key_hit[i];
    restart = key_hit[0] ? SW'(1) : SW'(0);
  end

  always_comb begin
    step_en = busy | rd_evt | wr_evt;
    step_d  = step_q;
    cmd_d   = CMD_NONE;
    if (busy || wr_evt) begin
      step_d = '0;
    end else if (rd_evt) begin
      if (step_q == LAST) begin
        if (store_hit)       cmd_d = CMD_STORE;
        else if (recall_hit) cmd_d = CMD_RECALL;
        step_d = (store_hit || recall_hit) ? SW'(0) : restart;
      end else if (cur_hit) begin
        step_d = step_q + SW'(1);
      end else begin
        step_d = restart;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cmd_q <= CMD_NONE;
    else         cmd_q <= cmd_d;
  end

  // R2
  store_from_full_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cmd_q == CMD_STORE) |-> ($past(step_q) == LAST));
  // R5
  write_abort_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_evt |=> (step_q == '0));
  // R7
  restart_two_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_evt && !busy && key_hit[0] && step_q != LAST) |=> (step_q != '0));
endmodule

// File: rtl/nvseq_cmd_detect.sv
module nvseq_cmd_detect
  import nvseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              acc_done,
  input  logic              ce_rd,
  input  logic              oe_rd,
  input  logic              we_on,
  input  logic [ADDR_W-1:0] addr,
  output logic              store_req,
  output logic              recall_req
);
  logic                rst_ns;
  logic                rd_evt, wr_evt;
  logic [NUM_KEYS-1:0] key_hit;
  logic                store_hit, recall_hit;
  cmd_e                cmd_q;

  nvseq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  nvseq_access_edge u_edge (
    .clk(clk), .rst_ns(rst_ns), .acc_done(acc_done), .ce_rd(ce_rd),
    .oe_rd(oe_rd), .we_on(we_on), .rd_evt(rd_evt), .wr_evt(wr_evt)
  );

  nvseq_key_match #(.N(NUM_KEYS), .W(ADDR_W)) u_match (
    .addr(addr), .key_hit(key_hit), .store_hit(store_hit),
    .recall_hit(recall_hit)
  );

  nvseq_chain_fsm #(.N(NUM_KEYS), .SW(STEP_W)) u_fsm (
    .clk(clk), .rst_ns(rst_ns), .busy(busy), .rd_evt(rd_evt),
    .wr_evt(wr_evt), .key_hit(key_hit), .store_hit(store_hit),
    .recall_hit(recall_hit), .cmd_q(cmd_q)
  );

  assign store_req  = (cmd_q == CMD_STORE);
  assign recall_req = (cmd_q == CMD_RECALL);

  // R10
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({store_req, recall_req}));
  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (store_req || recall_req) |=> !(store_req || recall_req));
  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |=> !(store_req || recall_req));
  // R3
  recall_addr_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    recall_req |-> ($past(addr) == RECALL_CODE && !$past(we_on)));
endmodule

// File: tb/nvseq_cmd_detect_tb.sv
module nvseq_cmd_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, acc_done = 1'b0, ce_rd = 1'b0, oe_rd = 1'b0, we_on = 1'b0;
  logic [15:0] addr = 16'h0;
  logic store_req, recall_req;

  int checks = 0, fails = 0, cyc = 0;
  logic mon_on = 1'b0;

  typedef struct { int due; logic s; logic r; string tag; } item_t;
  item_t sbq[$];

  localparam logic [15:0] K0 = 16'h4E38, K1 = 16'hB1C7, K2 = 16'h83E0,
                          K3 = 16'h7C1F, K4 = 16'h703F;
  localparam logic [15:0] ST = 16'h8FC0, RC = 16'h4C63;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvseq_cmd_detect u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .acc_done(acc_done),
    .ce_rd(ce_rd), .oe_rd(oe_rd), .we_on(we_on), .addr(addr),
    .store_req(store_req), .recall_req(recall_req)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {store,recall} actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops the scoreboard item due now, otherwise expects silence
  always @(negedge clk) begin
    if (mon_on) begin
      logic [1:0] exp;
      string tag;
      exp = 2'b00; tag = "R8 idle";
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        exp = {it.s, it.r}; tag = it.tag;
      end
      check(tag, {store_req, recall_req}, exp);
    end
  end

  // driver: one access, pushes the expected result for the following cycle
  task automatic acc(input logic [15:0] a, input logic ce, input logic oe,
                     input logic we, input int hold, input logic s,
                     input logic r, input string tag);
    @(negedge clk);
    addr = a; ce_rd = ce; oe_rd = oe; we_on = we; acc_done = 1'b1;
    sbq.push_back('{due: cyc + 1, s: s, r: r, tag: tag});
    repeat (hold) @(negedge clk);
    acc_done = 1'b0; ce_rd = 1'b0; oe_rd = 1'b0; we_on = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    acc(a, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0, tag);
  endtask

  task automatic prefix(input logic ce, input logic oe, input string tag);
    acc(K0, ce, oe, 1'b0, 1, 1'b0, 1'b0, tag);
    acc(K1, ce, oe, 1'b0, 1, 1'b0, 1'b0, tag);
    acc(K2, ce, oe, 1'b0, 1, 1'b0, 1'b0, tag);
    acc(K3, ce, oe, 1'b0, 1, 1'b0, 1'b0, tag);
    acc(K4, ce, oe, 1'b0, 1, 1'b0, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", {store_req, recall_req}, 2'b00);
    mon_on = 1'b1;

    // R2 store chain via chip enable
    prefix(1'b1, 1'b0, "R2");
    acc(ST, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1'b0, "R2 store");
    // R3 recall chain via output enable
    prefix(1'b0, 1'b1, "R3");
    acc(RC, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b1, "R3 recall");
    // R6 mixed qualifiers
    acc(K0, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R6");
    acc(K1, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b0, "R6");
    acc(K2, 1'b1, 1'b1, 1'b0, 1, 1'b0, 1'b0, "R6");
    acc(K3, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b0, "R6");
    acc(K4, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R6");
    acc(RC, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b1, "R6 mixed recall");
    // R4 wrong address at step three
    rd(K0, "R4"); rd(K1, "R4"); rd(16'h1234, "R4");
    rd(K2, "R4"); rd(K3, "R4"); rd(K4, "R4"); rd(ST, "R4 aborted");
    // R5 write with matching address at step four
    rd(K0, "R5"); rd(K1, "R5"); rd(K2, "R5");
    acc(K3, 1'b1, 1'b0, 1'b1, 1, 1'b0, 1'b0, "R5");
    rd(K4, "R5"); rd(ST, "R5 aborted");
    // R7 abort by first key restarts at step two
    rd(K0, "R7"); rd(K1, "R7"); rd(K2, "R7"); rd(K0, "R7");
    rd(K1, "R7"); rd(K2, "R7"); rd(K3, "R7"); rd(K4, "R7");
    acc(ST, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1'b0, "R7 store");
    rd(K0, "R7"); rd(K0, "R7"); rd(K1, "R7"); rd(K2, "R7"); rd(K3, "R7"); rd(K4, "R7");
    acc(RC, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b1, "R7 recall");
    // R8 long strobes count once
    acc(K0, 1'b1, 1'b0, 1'b0, 4, 1'b0, 1'b0, "R8");
    acc(K1, 1'b1, 1'b0, 1'b0, 3, 1'b0, 1'b0, "R8");
    rd(K2, "R8"); rd(K3, "R8"); rd(K4, "R8");
    acc(ST, 1'b1, 1'b0, 1'b0, 6, 1'b1, 1'b0, "R8 held store");
    // R9 busy mid chain
    rd(K0, "R9"); rd(K1, "R9"); rd(K2, "R9");
    @(negedge clk); busy = 1'b1;
    repeat (3) @(negedge clk); busy = 1'b0;
    rd(K3, "R9"); rd(K4, "R9"); rd(ST, "R9 cleared");
    // R9 chain completed under busy
    prefix(1'b1, 1'b0, "R9");
    @(negedge clk); busy = 1'b1;
    acc(ST, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R9 busy final");
    @(negedge clk); busy = 1'b0;
    // R11 command address alone, and a wrong sixth address
    prefix(1'b1, 1'b0, "R11");
    acc(ST, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1'b0, "R11 store");
    rd(ST, "R11 lone"); rd(RC, "R11 lone");
    prefix(1'b1, 1'b0, "R11");
    rd(16'h8FC1, "R11 wrong sixth");
    rd(ST, "R11 after wrong");
    // R12 no-strobe rise inside chain leaves progress
    rd(K0, "R12"); rd(K1, "R12");
    acc(16'h0BAD, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, "R12");
    rd(K2, "R12"); rd(K3, "R12");
    acc(16'hFFFF, 1'b0, 1'b0, 1'b0, 2, 1'b0, 1'b0, "R12");
    rd(K4, "R12");
    acc(RC, 1'b1, 1'b0, 1'b0, 1, 1'b0, 1'b1, "R12 recall");

    repeat (4) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R8 scoreboard: actual=%0d pending expected=0", sbq.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule